// File: doc/BRIEF.md
# Timer Compare-Output Waveform Unit

An 8-bit free-running timer with two compare channels, A and B, each of which steers one output pin. On every clock the counter advances by one step; when the count equals a channel's active compare value, or when the counter passes one of its end points, the channel's output level is set, cleared or inverted. What happens depends on the 2-bit action code of the channel and on the waveform mode of the timer: plain counting (with optional clear at a compare-A ceiling), single-slope PWM, or dual-slope (phase-correct) PWM.

Each channel reports whether its action code connects it to its pin (the override flag). The pin is driven with the channel's level only when the channel is connected and its output-enable bit is high. In both PWM modes the compare values are double-buffered, so a new duty cycle takes effect at the period boundary. There is no prescaler, interrupt or register bus: all controls are plain input ports, sampled on the rising clock edge.

Top module: `tcw_waveform_unit`

## Requirements
- R1: A synchronous active-high reset forces the count to 0, the count direction to up, both channel levels low and both buffered compare values to 0; during reset and right after it, both pins read 0.
- R2: A channel's override flag is high exactly when its action code is connected in the current waveform mode; the pin equals the channel level when the flag and the channel's enable are both high, and reads 0 otherwise.
- R3: Waveform select 00 or 10 (plain counting): code 01 inverts the level on a match, code 10 drives it low on a match, code 11 drives it high on a match, and code 00 disconnects; a match is a rising clock edge at which the count equals the channel's active compare value.
- R4: TOP is 255 when the ceiling select is 0 and the active compare-A value when it is 1. In plain counting (select 00/10) and single-slope PWM (select 11) the count goes from TOP to 0; in phase-correct PWM (select 01) it climbs to TOP, then falls back to 0, then climbs again, visiting each end point once.
- R5: Single-slope PWM: code 10 drives low on a match and high at the edge where the count goes from TOP to 0; code 11 does the reverse; the edge to 0 takes precedence over a match at that edge; for channel B code 01 and code 00 disconnect.
- R6: Phase-correct PWM: code 10 drives low on a match while counting up and high on a match while counting down; code 11 does the reverse; the direction is the one in force before the edge.
- R7: In either PWM mode, channel A code 01 inverts the level on a match when the ceiling select is 1, and disconnects the channel when it is 0.
- R8: In either PWM mode, when channel A's active compare value equals TOP and its code is 10 or 11, the match is ignored and at the TOP edge the level is driven high for code 10 and low for code 11.
- R9: In PWM modes the active compare values take the input values only at the TOP edge; in plain counting they take them at every edge.
- R10: While a channel is disconnected its level is held, so reconnecting resumes from the last level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wave_sel | input | 2 | Waveform mode: 00/10 plain, 01 phase-correct PWM, 11 single-slope PWM |
| top_from_a | input | 1 | 1: TOP is the active compare-A value; 0: TOP is 255 |
| code_a | input | 2 | Channel A action code |
| code_b | input | 2 | Channel B action code |
| cmp_a | input | 8 | Channel A compare value (buffered in PWM modes) |
| cmp_b | input | 8 | Channel B compare value (buffered in PWM modes) |
| oe_a | input | 1 | Channel A pin enable |
| oe_b | input | 1 | Channel B pin enable |
| count | output | 8 | Current counter value |
| pin_a | output | 1 | Channel A pin value |
| pin_b | output | 1 | Channel B pin value |
| ovr_a | output | 1 | Channel A has taken over its pin |
| ovr_b | output | 1 | Channel B has taken over its pin |

## Verification
The assertions assume that every control input is looked at only on the rising edge, and may change freely between edges, including mid-period changes of mode, code, ceiling select and compare values. The dual-slope climb check also takes for granted that a count above TOP simply turns around, so it only constrains cycles where the count sits below TOP. The stimulus changes inputs only at falling edges and holds them for whole runs of cycles, switching modes while the counter is mid-period so that buffering, direction at turnaround and the compare-equals-TOP case are all reached.

// File: rtl/tcw_pkg.sv
package tcw_pkg;

    typedef enum logic [1:0] {
        WAVE_PLAIN = 2'b00,
        WAVE_PHASE = 2'b01,
        WAVE_ALT   = 2'b10,
        WAVE_FAST  = 2'b11
    } wave_e;

    typedef enum logic [1:0] {
        OC_OFF = 2'b00,
        OC_TGL = 2'b01,
        OC_CLR = 2'b10,
        OC_SET = 2'b11
    } oc_code_e;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_TOGGLE,
        ACT_CLEAR,
        ACT_SET
    } oc_act_e;

    // Per-cycle timing events shared by both channels
    typedef struct packed {
        logic pwm;
        logic phase;
        logic fast;
        logic up;
        logic turn;
        logic top_from_a;
    } cnt_evt_t;

    function automatic logic wave_is_phase(wave_e w);
        return w == WAVE_PHASE;
    endfunction

    function automatic logic wave_is_fast(wave_e w);
        return w == WAVE_FAST;
    endfunction

    function automatic logic apply_act(logic cur, oc_act_e a);
        logic r;
        case (a)
            ACT_TOGGLE: r = ~cur;
            ACT_CLEAR:  r = 1'b0;
            ACT_SET:    r = 1'b1;
            default:    r = cur;
        endcase
        return r;
    endfunction

    // Level a PWM channel starts its active phase with
    function automatic oc_act_e start_level(oc_code_e c);
        return (c == OC_CLR) ? ACT_SET : ACT_CLEAR;
    endfunction

endpackage

// File: rtl/tcw_counter.sv
module tcw_counter
    import tcw_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  wave_e        wave,
    input  logic         top_sel,
    input  logic [W-1:0] ocr_a,
    output logic [W-1:0] cnt,
    output logic [W-1:0] top,
    output cnt_evt_t     evt
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] ZERO = '0;

    logic [W-1:0] cnt_q;
    logic         up_q;
    logic         phase;
    logic         fast;
    logic         turn;

    always_comb begin
        top   = top_sel ? ocr_a : MAXV;
        phase = wave_is_phase(wave);
        fast  = wave_is_fast(wave);
        turn  = phase ? (up_q && (cnt_q >= top)) : (cnt_q == top);
        evt.pwm        = phase | fast;
        evt.phase      = phase;
        evt.fast       = fast;
        evt.up         = up_q;
        evt.turn       = turn;
        evt.top_from_a = top_sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= ZERO;
            up_q  <= 1'b1;
        end else if (phase) begin
            if (up_q) begin
                if (turn) begin
                    if (cnt_q != ZERO) begin
                        cnt_q <= cnt_q - ONE;
                        up_q  <= 1'b0;
                    end
                end else begin
                    cnt_q <= cnt_q + ONE;
                end
            end else if (cnt_q == ZERO) begin
                up_q  <= 1'b1;
                cnt_q <= (top == ZERO) ? ZERO : ONE;
            end else begin
                cnt_q <= cnt_q - ONE;
            end
        end else begin
            up_q  <= 1'b1;
            cnt_q <= turn ? ZERO : (cnt_q + ONE);
        end
    end

    assign cnt = cnt_q;

    // R1: reset leaves count at bottom, counting up
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (cnt_q == ZERO) && up_q);

    // R4: single-slope and plain modes return to bottom after TOP
    a_r4_wrap_to_bottom: assert property (@(posedge clk) disable iff (rst)
        (!phase && cnt_q == top) |=> cnt_q == ZERO);

    // R4: dual-slope climbs one step at a time below TOP
    a_r4_phase_climb: assert property (@(posedge clk) disable iff (rst)
        (phase && up_q && cnt_q < top) |=> cnt_q == $past(cnt_q) + ONE);

endmodule

// File: rtl/tcw_cmp_buf.sv
module tcw_cmp_buf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pwm,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst)
            q_r <= '0;
        else if (!pwm || load)
            q_r <= d;
    end

    assign q = q_r;

    // R9: active compare value frozen inside a PWM period
    a_r9_hold_buffer: assert property (@(posedge clk) disable iff (rst)
        (pwm && !load) |=> $stable(q_r));

endmodule

// File: rtl/tcw_channel.sv
module tcw_channel
    import tcw_pkg::*;
#(
    parameter int W    = 8,
    parameter bit IS_A = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  oc_code_e     code,
    input  cnt_evt_t     evt,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] top,
    input  logic [W-1:0] cmp,
    input  logic         oe,
    output logic         pin,
    output logic         ovr
);
    logic    lvl_q;
    logic    connected;
    logic    match;
    logic    at_ceiling;
    oc_act_e act;

    always_comb begin
        match      = (cnt == cmp);
        at_ceiling = IS_A && (cmp == top);
        if (!evt.pwm)
            connected = (code != OC_OFF);
        else
            connected = code[1] || (IS_A && code == OC_TGL && evt.top_from_a);
    end

    always_comb begin
        act = ACT_HOLD;
        if (!connected) begin
            act = ACT_HOLD;
        end else if (code == OC_TGL) begin
            act = match ? ACT_TOGGLE : ACT_HOLD;
        end else if (!evt.pwm) begin
            if (match)
                act = (code == OC_SET) ? ACT_SET : ACT_CLEAR;
        end else if (evt.fast) begin
            if (evt.turn)
                act = start_level(code);
            else if (match)
                act = (code == OC_CLR) ? ACT_CLEAR : ACT_SET;
        end else if (at_ceiling) begin
            if (evt.turn)
                act = start_level(code);
        end else if (match) begin
            act = (evt.up == (code == OC_CLR)) ? ACT_CLEAR : ACT_SET;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            lvl_q <= 1'b0;
        else
            lvl_q <= apply_act(lvl_q, act);
    end

    assign ovr = connected;
    assign pin = (connected && oe) ? lvl_q : 1'b0;

    // R10: a disconnected channel keeps its level
    a_r10_hold_when_off: assert property (@(posedge clk) disable iff (rst)
        !connected |=> $stable(lvl_q));

    // R3: plain-mode set on match
    a_r3_set_on_match: assert property (@(posedge clk) disable iff (rst)
        (!evt.pwm && code == OC_SET && match) |=> lvl_q);

    // R5: non-inverting single-slope goes high at bottom
    a_r5_high_at_bottom: assert property (@(posedge clk) disable iff (rst)
        (evt.fast && code == OC_CLR && evt.turn) |=> lvl_q);

    // R6: non-inverting dual-slope goes low on an up-count match
    a_r6_up_clear: assert property (@(posedge clk) disable iff (rst)
        (evt.phase && code == OC_CLR && match && evt.up && !at_ceiling) |=> !lvl_q);

    generate
        if (IS_A) begin : g_ceiling_chk
            // R8: compare at TOP with inverting code ends low
            a_r8_ceiling_low: assert property (@(posedge clk) disable iff (rst)
                (evt.pwm && code == OC_SET && at_ceiling && evt.turn) |=> !lvl_q);
        end
    endgenerate

endmodule

// File: rtl/tcw_waveform_unit.sv
module tcw_waveform_unit
    import tcw_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   wave_sel,
    input  logic         top_from_a,
    input  logic [1:0]   code_a,
    input  logic [1:0]   code_b,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    input  logic         oe_a,
    input  logic         oe_b,
    output logic [W-1:0] count,
    output logic         pin_a,
    output logic         pin_b,
    output logic         ovr_a,
    output logic         ovr_b
);
    localparam int NCH = 2;

    wave_e        wave;
    cnt_evt_t     evt;
    logic [W-1:0] top;
    logic [W-1:0] cnt;
    logic [W-1:0] cmp_in  [NCH];
    logic [W-1:0] cmp_act [NCH];
    oc_code_e     codes   [NCH];
    logic         oes     [NCH];
    logic         pins    [NCH];
    logic         ovrs    [NCH];

    always_comb begin
        wave      = wave_e'(wave_sel);
        cmp_in[0] = cmp_a;
        cmp_in[1] = cmp_b;
        codes[0]  = oc_code_e'(code_a);
        codes[1]  = oc_code_e'(code_b);
        oes[0]    = oe_a;
        oes[1]    = oe_b;
    end

    tcw_counter #(.W(W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .wave    (wave),
        .top_sel (top_from_a),
        .ocr_a   (cmp_act[0]),
        .cnt     (cnt),
        .top     (top),
        .evt     (evt)
    );

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            tcw_cmp_buf #(.W(W)) u_buf (
                .clk  (clk),
                .rst  (rst),
                .pwm  (evt.pwm),
                .load (evt.turn),
                .d    (cmp_in[ch]),
                .q    (cmp_act[ch])
            );

            tcw_channel #(.W(W), .IS_A(ch == 0)) u_chan (
                .clk  (clk),
                .rst  (rst),
                .code (codes[ch]),
                .evt  (evt),
                .cnt  (cnt),
                .top  (top),
                .cmp  (cmp_act[ch]),
                .oe   (oes[ch]),
                .pin  (pins[ch]),
                .ovr  (ovrs[ch])
            );
        end
    endgenerate

    assign count = cnt;
    assign pin_a = pins[0];
    assign pin_b = pins[1];
    assign ovr_a = ovrs[0];
    assign ovr_b = ovrs[1];

    // R2: a pin without its enable stays quiet
    a_r2_pin_quiet_a: assert property (@(posedge clk) disable iff (rst)
        !oe_a |-> !pin_a);
    a_r2_pin_quiet_b: assert property (@(posedge clk) disable iff (rst)
        !oe_b |-> !pin_b);

endmodule

// File: tb/tcw_waveform_unit_tb.sv
`timescale 1ns/1ps
module tcw_waveform_unit_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] wave_sel;
    logic       top_from_a;
    logic [1:0] code_a, code_b;
    logic [7:0] cmp_a, cmp_b;
    logic       oe_a, oe_b;
    logic [7:0] count;
    logic       pin_a, pin_b, ovr_a, ovr_b;

    always #2.5 clk = ~clk;

    tcw_waveform_unit #(.W(8)) u_dut (
        .clk(clk), .rst(rst), .wave_sel(wave_sel), .top_from_a(top_from_a),
        .code_a(code_a), .code_b(code_b), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .oe_a(oe_a), .oe_b(oe_b), .count(count),
        .pin_a(pin_a), .pin_b(pin_b), .ovr_a(ovr_a), .ovr_b(ovr_b)
    );

    // stimulus settings used by the driver
    bit       s_rst;
    int       s_wave, s_code_a, s_code_b, s_cmp_a, s_cmp_b;
    bit       s_top_a, s_oe_a, s_oe_b;
    string    s_tag;

    // reference state, built from the requirements
    int m_cnt, m_qa, m_qb;
    bit m_up, m_la, m_lb;

    // scoreboard: {count, pin_a, pin_b, ovr_a, ovr_b}
    logic [11:0] exp_q [$];
    string       tag_q [$];

    int  checks   = 0;
    int  failures = 0;
    bit  finished = 0;

    function automatic bit is_pwm_w(int w);
        return (w == 1) || (w == 3);
    endfunction

    function automatic bit conn_of(bit is_a, int code, int w, bit ta);
        if (!is_pwm_w(w)) return code != 0;
        if (code >= 2) return 1'b1;
        return is_a && code == 1 && ta;
    endfunction

    function automatic bit chan_next(bit is_a, int code, bit lvl, int q, int tp,
                                     int w, bit ta, int c, bit up, bit turn);
        bit hit;
        hit = (c == q);
        if (!conn_of(is_a, code, w, ta)) return lvl;
        if (code == 1) return hit ? ~lvl : lvl;
        if (!is_pwm_w(w)) return hit ? (code == 3) : lvl;
        if (w == 3) begin
            if (turn) return code == 2;
            return hit ? (code == 3) : lvl;
        end
        if (is_a && q == tp) return turn ? (code == 2) : lvl;
        if (!hit) return lvl;
        return up ? (code == 3) : (code == 2);
    endfunction

    task automatic model_step();
        int  tp;
        bit  turn, na, nb;
        if (s_rst) begin
            m_cnt = 0; m_up = 1; m_la = 0; m_lb = 0; m_qa = 0; m_qb = 0;
        end else begin
            tp   = s_top_a ? m_qa : 255;
            turn = (s_wave == 1) ? (m_up && m_cnt >= tp) : (m_cnt == tp);
            na = chan_next(1'b1, s_code_a, m_la, m_qa, tp, s_wave, s_top_a, m_cnt, m_up, turn);
            nb = chan_next(1'b0, s_code_b, m_lb, m_qb, tp, s_wave, s_top_a, m_cnt, m_up, turn);
            m_la = na; m_lb = nb;
            if (!is_pwm_w(s_wave) || turn) begin
                m_qa = s_cmp_a; m_qb = s_cmp_b;
            end
            if (s_wave == 1) begin
                if (m_up) begin
                    if (turn) begin
                        if (m_cnt != 0) begin m_cnt = m_cnt - 1; m_up = 0; end
                    end else m_cnt = m_cnt + 1;
                end else if (m_cnt == 0) begin
                    m_up = 1; m_cnt = (tp == 0) ? 0 : 1;
                end else m_cnt = m_cnt - 1;
            end else begin
                m_up  = 1;
                m_cnt = turn ? 0 : (m_cnt + 1) % 256;
            end
        end
    endtask

    // driver: apply settings at the falling edge and queue what must follow
    task automatic run(input int n, input string tag);
        bit va, vb, pa, pb;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rst        = s_rst;
            wave_sel   = s_wave[1:0];
            top_from_a = s_top_a;
            code_a     = s_code_a[1:0];
            code_b     = s_code_b[1:0];
            cmp_a      = s_cmp_a[7:0];
            cmp_b      = s_cmp_b[7:0];
            oe_a       = s_oe_a;
            oe_b       = s_oe_b;
            model_step();
            va = s_rst ? 1'b0 : conn_of(1'b1, s_code_a, s_wave, s_top_a);
            vb = s_rst ? 1'b0 : conn_of(1'b0, s_code_b, s_wave, s_top_a);
            if (s_rst) begin
                va = conn_of(1'b1, s_code_a, s_wave, s_top_a);
                vb = conn_of(1'b0, s_code_b, s_wave, s_top_a);
            end
            pa = va && s_oe_a && m_la;
            pb = vb && s_oe_b && m_lb;
            exp_q.push_back({m_cnt[7:0], pa, pb, va, vb});
            tag_q.push_back(tag);
        end
    endtask

    // monitor: compare shortly after each rising edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [11:0] e;
            logic [11:0] a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {count, pin_a, pin_b, ovr_a, ovr_b};
            checks++;
            if (a !== e) begin
                failures++;
                $display("FAIL %s: actual cnt=%0d pa=%b pb=%b oa=%b ob=%b expected cnt=%0d pa=%b pb=%b oa=%b ob=%b",
                         t, a[11:4], a[3], a[2], a[1], a[0], e[11:4], e[3], e[2], e[1], e[0]);
            end
        end
    end

    initial begin
        rst = 1; wave_sel = 0; top_from_a = 0; code_a = 0; code_b = 0;
        cmp_a = 0; cmp_b = 0; oe_a = 1; oe_b = 1;
        s_rst = 1; s_wave = 0; s_top_a = 0; s_code_a = 1; s_code_b = 3;
        s_cmp_a = 0; s_cmp_b = 0; s_oe_a = 1; s_oe_b = 1;
        run(4, "R1 reset");
        s_rst = 0;
        run(3, "R1 after reset");

        // R3 plain counting: toggle on A, clear then set on B
        s_code_a = 1; s_code_b = 2; s_cmp_a = 10; s_cmp_b = 40;
        run(300, "R3 toggle/clear");
        s_code_b = 3;
        run(300, "R3 set");

        // R4 plain counting with compare-A ceiling
        s_top_a = 1; s_cmp_a = 20;
        run(100, "R4 ceiling wrap");

        // R10 level held while disconnected, resumed after
        s_code_a = 3;
        run(30, "R10 set first");
        s_code_a = 0;
        run(50, "R10 disconnected");
        s_code_a = 1;
        run(50, "R10 reconnected");

        // R5 single-slope PWM
        s_wave = 3; s_top_a = 0; s_cmp_a = 100; s_cmp_b = 200;
        s_code_a = 2; s_code_b = 3;
        run(600, "R5 non-inverting/inverting");
        s_code_b = 1;
        run(300, "R5 B code 01 off");

        // R9 duty change mid-period
        s_code_b = 2; s_cmp_b = 60;
        run(120, "R9 before TOP");
        s_cmp_b = 180; s_cmp_a = 30;
        run(500, "R9 buffered");

        // R7 channel A toggle code in PWM modes
        s_top_a = 1; s_cmp_a = 60; s_code_a = 1;
        run(300, "R7 fast toggle");
        s_top_a = 0;
        run(300, "R7 fast off");

        // R6 phase-correct PWM
        s_wave = 1; s_cmp_a = 80; s_cmp_b = 30; s_code_a = 2; s_code_b = 3;
        run(1100, "R6 dual slope");
        s_top_a = 1; s_cmp_a = 90; s_code_a = 1; s_code_b = 2; s_cmp_b = 40;
        run(500, "R7 phase toggle");
        s_top_a = 0;
        run(200, "R7 phase off");

        // R8 compare equal to TOP on channel A
        s_top_a = 1; s_cmp_a = 70; s_code_a = 2;
        run(400, "R8 code 10 at TOP");
        s_code_a = 3;
        run(400, "R8 code 11 at TOP");
        s_wave = 3; s_code_a = 2;
        run(300, "R8 single slope");

        // R2 enables and override flags
        s_wave = 1; s_top_a = 0; s_cmp_a = 50; s_code_a = 2; s_code_b = 3;
        s_oe_a = 0;
        run(300, "R2 A disabled");
        s_oe_a = 1; s_oe_b = 0;
        run(300, "R2 B disabled");
        s_oe_b = 1; s_code_b = 0;
        run(100, "R2 B off");

        // R1 reset again mid-run
        s_rst = 1;
        run(3, "R1 re-reset");
        s_rst = 0;
        run(20, "R1 restart");

        while (exp_q.size() > 0) @(posedge clk);
        @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule